// File: doc/BRIEF.md
# Packed-Vector Per-Lane Bit Clear Unit

This execution unit sits in a 128-bit packed-vector pipeline. Each cycle it may accept one 32-bit instruction word with the two source vector values that the register fields have already selected. If the word encodes the bit-clear operation and the vector unit is turned on, every lane of the first source has exactly one bit forced to zero. The position of that bit comes from the matching lane of the second source. The 128-bit result and the destination register index come out one cycle later. Lanes are 8, 16, 32 or 64 bits wide, and a 2-bit format field in the instruction picks the width at run time.

The unit raises one of two faults in place of a result. One is a disabled fault, raised when the vector unit is off. The other is a reserved-instruction fault, raised when the word is not a bit-clear encoding. The operand values never cause a fault. The output stage is a small state machine that holds what the previous cycle produced. It has four states. ST_IDLE means nothing was issued. ST_RESULT means a valid result is present. ST_FLT_OFF means a disabled fault. ST_FLT_RSV means a reserved-instruction fault. Any state can move to any state on each clock edge. An idle input leads to ST_IDLE. An issue while the unit is off leads to ST_FLT_OFF. An issue of a word that does not match, with the unit on, leads to ST_FLT_RSV. An issue of a matching word with the unit on leads to ST_RESULT. Reset forces ST_IDLE.

Top module: `vbitclr_unit`

## Requirements
- R1: A word is the bit-clear operation when bits 31:26 = 6'b011110, bits 25:23 = 3'b011 and bits 5:0 = 6'b001101. Bits 22:21 are the format, 20:16 the second-source index, 15:11 the first-source index and 10:6 the destination index. For such a word, issued with the unit on, out_dst equals bits 10:6 in the cycle after issue.
- R2: Format 2'b00 selects 8-bit lanes (16 lanes), 2'b01 selects 16-bit (8 lanes), 2'b10 selects 32-bit (4 lanes) and 2'b11 selects 64-bit (2 lanes). Lane i occupies bits i*W+W-1 down to i*W.
- R3: Each result lane equals the first-source lane with one bit cleared. All other bits are unchanged, and no bit is ever set that was clear in the first source.
- R4: The cleared position is the second-source lane value modulo the width. Only its low log2(W) bits are used (2:0, 3:0, 4:0 or 5:0 of the lane), and its upper bits have no effect on the result.
- R5: out_valid rises exactly one cycle after an accepted issue. A cycle with in_valid low leaves out_valid, flt_off and flt_resv all low in the next cycle.
- R6: An issue with unit_en low gives flt_off high and out_valid low in the next cycle, whatever the instruction word. This fault takes priority over the reserved-instruction fault.
- R7: An issue with unit_en high and a word that fails the R1 match gives flt_resv high and out_valid low in the next cycle.
- R8: A clock edge with rst_n low clears out_valid, flt_off and flt_resv, even while in_valid is high.
- R9: A matching word with the unit on never raises a fault, whatever the operand values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction issued this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 128 | First source vector (data to clear) |
| src_b | input | 128 | Second source vector (bit positions) |
| unit_en | input | 1 | Vector unit turned on |
| out_valid | output | 1 | Result valid |
| out_data | output | 128 | Result vector |
| out_dst | output | 5 | Destination register index |
| flt_off | output | 1 | Vector-unit-disabled fault |
| flt_resv | output | 1 | Reserved-instruction fault |

## Verification
The assertions assume that in_valid, instr, unit_en and both sources are settled before each rising edge. They also assume every input is driven to a known value from time zero, because the properties compare outputs with the previous cycle's inputs through $past. The bench drives all inputs on the falling edge, starting from defined values before reset is released. It mixes matching words in all four formats with words that have damaged opcode, minor or function fields. It runs issues with the unit both on and off, and it leaves idle gaps between them. Second-source lanes carry random upper bits, so the modulo behaviour is compared against the model in every format.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
    localparam int VLEN     = 128;
    localparam int NUM_FMT  = 4;
    localparam int IW       = 32;
    localparam int RIDX_W   = 5;

    localparam logic [5:0] MAJOR_OP = 6'b011110;
    localparam logic [2:0] MINOR_OP = 3'b011;
    localparam logic [5:0] FUNC_OP  = 6'b001101;

    typedef enum logic [1:0] {
        FMT_B = 2'b00,
        FMT_H = 2'b01,
        FMT_W = 2'b10,
        FMT_D = 2'b11
    } elem_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESULT,
        ST_FLT_OFF,
        ST_FLT_RSV
    } out_state_e;
endpackage

// File: rtl/vbc_decode.sv
module vbc_decode
    import vbc_pkg::*;
(
    input  logic [IW-1:0]     instr,
    output logic              hit,
    output elem_fmt_e         fmt,
    output logic [RIDX_W-1:0] dst
);
    always_comb begin
        hit = (instr[31:26] == MAJOR_OP) &&
              (instr[25:23] == MINOR_OP) &&
              (instr[5:0]   == FUNC_OP);
        fmt = elem_fmt_e'(instr[22:21]);
        dst = instr[10:6];
    end
endmodule

// File: rtl/vbc_clear_dp.sv
module vbc_clear_dp
    import vbc_pkg::*;
#(
    parameter int W_VEC = VLEN
) (
    input  logic [W_VEC-1:0] a,
    input  logic [W_VEC-1:0] b,
    input  elem_fmt_e        fmt,
    output logic [W_VEC-1:0] res
);
    logic [W_VEC-1:0] res_by_fmt [NUM_FMT];

    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
        localparam int EW    = 8 << g;
        localparam int LANES = W_VEC / EW;
        localparam int PW    = $clog2(EW);
        localparam logic [EW-1:0] ONE = 1;
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [PW-1:0] pos;
            assign pos = b[l*EW +: PW];
            assign res_by_fmt[g][l*EW +: EW] = a[l*EW +: EW] & ~(ONE << pos);
        end
    end

    always_comb res = res_by_fmt[fmt];
endmodule

// File: rtl/vbitclr_unit.sv
module vbitclr_unit
    import vbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic [127:0]     src_a,
    input  logic [127:0]     src_b,
    input  logic             unit_en,
    output logic             out_valid,
    output logic [127:0]     out_data,
    output logic [4:0]       out_dst,
    output logic             flt_off,
    output logic             flt_resv
);
    logic              dec_hit;
    elem_fmt_e         dec_fmt;
    logic [RIDX_W-1:0] dec_dst;
    logic [VLEN-1:0]   dp_res;
    out_state_e        state_q, state_d;
    logic [VLEN-1:0]   data_q;
    logic [RIDX_W-1:0] dst_q;

    vbc_decode u_dec (
        .instr (instr),
        .hit   (dec_hit),
        .fmt   (dec_fmt),
        .dst   (dec_dst)
    );

    vbc_clear_dp #(.W_VEC(VLEN)) u_dp (
        .a   (src_a),
        .b   (src_b),
        .fmt (dec_fmt),
        .res (dp_res)
    );

    always_comb begin
        if (!in_valid)     state_d = ST_IDLE;
        else if (!unit_en) state_d = ST_FLT_OFF;
        else if (!dec_hit) state_d = ST_FLT_RSV;
        else               state_d = ST_RESULT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
            dst_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_RESULT) begin
                data_q <= dp_res;
                dst_q  <= dec_dst;
            end
        end
    end

    always_comb begin
        out_valid = 1'b0;
        flt_off   = 1'b0;
        flt_resv  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_RESULT:  out_valid = 1'b1;
            ST_FLT_OFF: flt_off   = 1'b1;
            ST_FLT_RSV: flt_resv  = 1'b1;
            default:    ;
        endcase
        out_data = data_q;
        out_dst  = dst_q;
    end

    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(out_valid || flt_off || flt_resv));

    assert_off_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !unit_en) |=> (flt_off && !flt_resv && !out_valid));

    assert_resv_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && unit_en && !dec_hit) |=> (flt_resv && !out_valid));

    assert_only_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && unit_en && dec_hit) |=>
            (out_valid && !flt_off && !flt_resv &&
             ((out_data & ~$past(src_a)) == '0) &&
             ($countones($past(src_a) ^ out_data) <= 16)));

    assert_dst_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && unit_en && dec_hit) |=> (out_dst == $past(instr[10:6])));
endmodule

// File: tb/vbitclr_unit_tb_top.sv
module vbitclr_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         unit_en = 1'b0;
    logic         out_valid;
    logic [127:0] out_data;
    logic [4:0]   out_dst;
    logic         flt_off;
    logic         flt_resv;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbitclr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .unit_en(unit_en),
        .out_valid(out_valid), .out_data(out_data), .out_dst(out_dst),
        .flt_off(flt_off), .flt_resv(flt_resv)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [31:0] mk_word(input logic [1:0] fmt, input logic [4:0] wd);
        return {6'b011110, 3'b011, fmt, 5'($urandom), 5'($urandom), wd, 6'b001101};
    endfunction

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [1:0] fmt);
        logic [127:0] r = a;
        int w = 8 << fmt;
        for (int i = 0; i < 128 / w; i++) begin
            int t = int'(b[i*w +: 6]) % w;
            r[i*w + t] = 1'b0;
        end
        return r;
    endfunction

    task automatic step(input bit v, input logic [31:0] w, input logic [127:0] a,
                        input logic [127:0] b, input bit en);
        bit match = (w[31:26] == 6'b011110) && (w[25:23] == 3'b011) && (w[5:0] == 6'b001101);
        bit e_v = v && en && match;
        bit e_off = v && !en;
        bit e_rsv = v && en && !match;
        logic [127:0] e_d = model(a, b, w[22:21]);
        in_valid = v; instr = w; src_a = a; src_b = b; unit_en = en;
        @(negedge clk);
        chk(out_valid == e_v, v ? "R5 valid timing" : "R5 idle valid", 128'(out_valid), 128'(e_v));
        chk(flt_off == e_off, "R6 disabled fault", 128'(flt_off), 128'(e_off));
        chk(flt_resv == e_rsv, e_v ? "R9 no data fault" : "R7 reserved fault",
            128'(flt_resv), 128'(e_rsv));
        if (e_v) begin
            chk(out_data == e_d, "R2 R3 R4 lane clear", out_data, e_d);
            chk(out_dst == w[10:6], "R1 dest index", 128'(out_dst), 128'(w[10:6]));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!out_valid && !flt_off && !flt_resv, "R8 reset state",
            128'({out_valid, flt_off, flt_resv}), 128'(0));
        rst_n = 1'b1;

        // Directed: position zero, max position, and upper bits set (R4)
        for (int f = 0; f < 4; f++) begin
            step(1, mk_word(2'(f), 5'(f + 3)), '1, '0, 1);
            step(1, mk_word(2'(f), 5'(f + 9)), '1, {16{8'hFF}}, 1);
            step(1, mk_word(2'(f), 5'(f + 17)), rnd128(), {16{8'hC1}}, 1);
        end

        // Random mix of formats, faults and idle gaps
        for (int n = 0; n < 400; n++) begin
            int kind = int'($urandom % 8);
            logic [31:0] w = mk_word(2'($urandom), 5'($urandom));
            if (kind == 5) w[31:26] = w[31:26] ^ 6'(1 + $urandom % 63);
            if (kind == 6) w[25:23] = w[25:23] ^ 3'(1 + $urandom % 7);
            if (kind == 7) w[5:0] = w[5:0] ^ 6'(1 + $urandom % 63);
            step(kind != 4, w, rnd128(), rnd128(), ($urandom % 6) != 0);
        end

        // R6 priority: bad word with unit off gives only the disabled fault
        step(1, 32'h0, rnd128(), rnd128(), 0);

        // R8: reset while an issue is presented
        in_valid = 1'b1; instr = mk_word(2'b10, 5'd4); unit_en = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk(!out_valid && !flt_off && !flt_resv, "R8 reset with issue",
            128'({out_valid, flt_off, flt_resv}), 128'(0));
        rst_n = 1'b1;
        step(1, mk_word(2'b11, 5'd31), rnd128(), rnd128(), 1);
        step(0, '0, '0, '0, 1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule